// File: doc/BRIEF.md
# Instruction Protection Level Table

This block is a small fully associative table that tells the pipeline how strongly each executed instruction must be guarded by redundant execution. Software loads pairs of an instruction address and a vulnerability score (an unsigned percentage from 0 to 100). The score is turned into a protection level when the entry is loaded, so only the level is kept. The conversion uses either a run-time programmable threshold or a fixed three-tier split.

Only addresses with a non-default level take a slot. A lookup port takes the address of every executed instruction and returns a hit flag and the level in the same cycle. An address that is not in the table reads back as level 0, meaning no protection. A synchronous clear empties the table.

Top module: `prot_level_table`

## Requirements
- R1: After reset the table is empty, every lookup returns hit 0 and level 0, the overflow flag is 0, and the threshold holds THR_RESET (default 1).
- R2: The lookup is combinational. In the same cycle as lkPc, lkHit is 1 only if that address holds an entry, and lkLevel gives that entry's level. On a miss, lkLevel is 0.
- R3: When tierMode is 0, a load whose score is greater than or equal to the threshold stores level 2 (protected). A lower score gives level 0 (unprotected).
- R4: A threshold write (thrWrEn) takes effect at the clock edge. A load in the same cycle still converts with the previous threshold value.
- R5: When tierMode is 1, a score below 1 gives level 0. A score from 1 to 98 gives level 1 (medium). A score of 99 or more gives level 2 (maximum).
- R6: Loading an address already in the table overwrites its level in place. An address never occupies more than one entry.
- R7: Only non-default levels are kept. A load that converts to level 0 removes an existing entry for that address, or changes nothing if the address is absent. It never raises overflow.
- R8: A load of a new address with a non-default level when all ENTRIES slots are in use is refused. The table is left unchanged and overflow goes to 1. It stays 1 until clrTable.
- R9: clrTable empties the table and clears overflow at the next edge. It takes priority over a load in the same cycle.
- R10: A slot freed by a removal (R7) is reused by the next new address, even while overflow is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clrTable | input | 1 | Synchronous clear of all entries and of overflow |
| ldValid | input | 1 | Load strobe |
| ldPc | input | PC_W | Address of the instruction being loaded |
| ldScore | input | SCORE_W | Vulnerability score, 0 to 100 |
| thrWrEn | input | 1 | Threshold write strobe |
| thrWrData | input | SCORE_W | New threshold value |
| tierMode | input | 1 | 0: threshold split into levels 0/2; 1: three-tier split |
| lkPc | input | PC_W | Address of the executed instruction to look up |
| lkHit | output | 1 | Lookup address is present |
| lkLevel | output | 2 | Protection level: 0 none, 1 medium, 2 maximum |
| overflow | output | 1 | Sticky flag: a load was refused because the table was full |

## Verification
Several internal faults show up at the lookup port on the very next cycle after the load that caused them:
- A slot left valid after a drop or clear reads as a stray hit.
- A wrong free-slot pick overwrites a live entry, so a previously loaded address starts to miss.
- A bad comparison at the threshold or tier boundaries returns the wrong level for that address.

Some faults only appear later:
- A duplicated address shows as wrong levels after a later overwrite.
- A slot-count error shows when the table fills, as overflow asserting early or too late.

The bench therefore compares hit, level and overflow with a behavioural model on every cycle. It walks the boundary scores, repeated loads, and loads while the table is full.

// File: rtl/plt_pkg.sv
package plt_pkg;

  // Level encoding seen at the lookup port
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_MED  = 2'd1,
    LVL_MAX  = 2'd2
  } protLvl_e;

  // Strobes from control to the entry storage
  typedef struct packed {
    logic wrEn;    // write the selected slot with ldPc / converted level
    logic dropEn;  // invalidate the selected slot
    logic clrAll;  // invalidate every slot
  } tblStrobe_t;

endpackage

// File: rtl/plt_store.sv
module plt_store
  import plt_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int PC_W      = 32,
  parameter int SCORE_W   = 7,
  parameter int THR_RESET = 1,
  parameter int LOW_CUT   = 1,
  parameter int HIGH_CUT  = 99
) (
  input  logic               clk,
  input  logic               rstN,
  input  tblStrobe_t         strobe,
  input  logic [ENTRIES-1:0] slotSel,
  input  logic [PC_W-1:0]    ldPc,
  input  logic [SCORE_W-1:0] ldScore,
  input  logic               thrWrEn,
  input  logic [SCORE_W-1:0] thrWrData,
  input  logic               tierMode,
  input  logic [PC_W-1:0]    lkPc,
  output protLvl_e           ldLevel,
  output logic [ENTRIES-1:0] ldMatch,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] lkMatch,
  output logic               lkHit,
  output logic [1:0]         lkLevel
);

  localparam logic [SCORE_W-1:0] THR_INIT = SCORE_W'(THR_RESET);
  localparam logic [SCORE_W-1:0] LOW_C    = SCORE_W'(LOW_CUT);
  localparam logic [SCORE_W-1:0] HIGH_C   = SCORE_W'(HIGH_CUT);

  logic [SCORE_W-1:0] thrQ;
  logic [1:0]         lvlArr [ENTRIES];

  // Runtime threshold register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        thrQ <= THR_INIT;
    else if (thrWrEn) thrQ <= thrWrData;
  end

  // Score to level conversion, done before the entry is written
  always_comb begin
    if (tierMode) begin
      if (ldScore >= HIGH_C)     ldLevel = LVL_MAX;
      else if (ldScore >= LOW_C) ldLevel = LVL_MED;
      else                       ldLevel = LVL_NONE;
    end else begin
      ldLevel = (ldScore >= thrQ) ? LVL_MAX : LVL_NONE;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : gEnt
    logic            vQ;
    logic [PC_W-1:0] pcQ;
    logic [1:0]      lvQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vQ  <= 1'b0;
        pcQ <= '0;
        lvQ <= LVL_NONE;
      end else if (strobe.clrAll) begin
        vQ <= 1'b0;
      end else if (strobe.wrEn && slotSel[g]) begin
        vQ  <= 1'b1;
        pcQ <= ldPc;
        lvQ <= ldLevel;
      end else if (strobe.dropEn && slotSel[g]) begin
        vQ <= 1'b0;
      end
    end

    assign validVec[g] = vQ;
    assign ldMatch[g]  = vQ && (pcQ == ldPc);
    assign lkMatch[g]  = vQ && (pcQ == lkPc);
    assign lvlArr[g]   = lvQ;
  end

  // Lookup: at most one slot matches, so an OR of gated levels suffices
  always_comb begin
    lkLevel = LVL_NONE;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lkMatch[i]) lkLevel = lkLevel | lvlArr[i];
    end
  end

  assign lkHit = |lkMatch;

endmodule

// File: rtl/plt_ctrl.sv
module plt_ctrl
  import plt_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clrTable,
  input  logic               ldValid,
  input  protLvl_e           ldLevel,
  input  logic [ENTRIES-1:0] ldMatch,
  input  logic [ENTRIES-1:0] validVec,
  output tblStrobe_t         strobe,
  output logic [ENTRIES-1:0] slotSel,
  output logic               overflow
);

  logic               hitAny;
  logic               tblFull;
  logic               isDefault;
  logic               setOvf;
  logic [ENTRIES-1:0] freeSlot;

  assign hitAny    = |ldMatch;
  assign tblFull   = &validVec;
  assign isDefault = (ldLevel == LVL_NONE);
  // lowest clear bit of validVec as a one-hot vector
  assign freeSlot  = ~validVec & (validVec + ENTRIES'(1));

  always_comb begin
    strobe        = '0;
    slotSel       = '0;
    setOvf        = 1'b0;
    strobe.clrAll = clrTable;
    if (!clrTable && ldValid) begin
      if (isDefault) begin
        if (hitAny) begin
          strobe.dropEn = 1'b1;
          slotSel       = ldMatch;
        end
      end else if (hitAny) begin
        strobe.wrEn = 1'b1;
        slotSel     = ldMatch;
      end else if (!tblFull) begin
        strobe.wrEn = 1'b1;
        slotSel     = freeSlot;
      end else begin
        setOvf = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         overflow <= 1'b0;
    else if (clrTable) overflow <= 1'b0;
    else if (setOvf)   overflow <= 1'b1;
  end

endmodule

// File: rtl/prot_level_table.sv
module prot_level_table
  import plt_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int PC_W      = 32,
  parameter int SCORE_W   = 7,
  parameter int THR_RESET = 1,
  parameter int LOW_CUT   = 1,
  parameter int HIGH_CUT  = 99
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clrTable,
  input  logic               ldValid,
  input  logic [PC_W-1:0]    ldPc,
  input  logic [SCORE_W-1:0] ldScore,
  input  logic               thrWrEn,
  input  logic [SCORE_W-1:0] thrWrData,
  input  logic               tierMode,
  input  logic [PC_W-1:0]    lkPc,
  output logic               lkHit,
  output logic [1:0]         lkLevel,
  output logic               overflow
);

  tblStrobe_t         strobe;
  logic [ENTRIES-1:0] slotSel;
  protLvl_e           ldLevel;
  logic [ENTRIES-1:0] ldMatch;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] lkMatchVec;

  plt_ctrl #(.ENTRIES(ENTRIES)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .clrTable (clrTable),
    .ldValid  (ldValid),
    .ldLevel  (ldLevel),
    .ldMatch  (ldMatch),
    .validVec (validVec),
    .strobe   (strobe),
    .slotSel  (slotSel),
    .overflow (overflow)
  );

  plt_store #(
    .ENTRIES  (ENTRIES),
    .PC_W     (PC_W),
    .SCORE_W  (SCORE_W),
    .THR_RESET(THR_RESET),
    .LOW_CUT  (LOW_CUT),
    .HIGH_CUT (HIGH_CUT)
  ) store_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .slotSel  (slotSel),
    .ldPc     (ldPc),
    .ldScore  (ldScore),
    .thrWrEn  (thrWrEn),
    .thrWrData(thrWrData),
    .tierMode (tierMode),
    .lkPc     (lkPc),
    .ldLevel  (ldLevel),
    .ldMatch  (ldMatch),
    .validVec (validVec),
    .lkMatch  (lkMatchVec),
    .lkHit    (lkHit),
    .lkLevel  (lkLevel)
  );

endmodule

// File: rtl/prot_level_table_chk.sv
module prot_level_table_chk #(
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               clrTable,
  input logic               lkHit,
  input logic [1:0]         lkLevel,
  input logic               overflow,
  input logic [ENTRIES-1:0] lkMatchVec
);

  AST_MISS_IS_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> (lkLevel == 2'd0)); // R2

  AST_HIT_NOT_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> (lkLevel != 2'd0) && (lkLevel != 2'd3)); // R7

  AST_PC_UNIQUE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkMatchVec)); // R6

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    clrTable |=> !lkHit && !overflow); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !clrTable |=> overflow); // R8

endmodule

bind prot_level_table prot_level_table_chk #(.ENTRIES(ENTRIES)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .clrTable  (clrTable),
  .lkHit     (lkHit),
  .lkLevel   (lkLevel),
  .overflow  (overflow),
  .lkMatchVec(lkMatchVec)
);

// File: tb/prot_level_table_tb_top.sv
module prot_level_table_tb_top;

  localparam int ENT  = 8;
  localparam int THR0 = 1;

  logic        clk = 1'b0;
  logic        rstN;
  logic        clrTable;
  logic        ldValid;
  logic [31:0] ldPc;
  logic [6:0]  ldScore;
  logic        thrWrEn;
  logic [6:0]  thrWrData;
  logic        tierMode;
  logic [31:0] lkPc;
  logic        lkHit;
  logic [1:0]  lkLevel;
  logic        overflow;

  int nChk  = 0;
  int nFail = 0;
  bit done  = 0;

  // behavioural reference state
  int unsigned mdl [int unsigned];
  bit          mOvf;
  int          mThr;

  always #5 clk = ~clk;

  prot_level_table dut_i (
    .clk(clk), .rstN(rstN), .clrTable(clrTable), .ldValid(ldValid),
    .ldPc(ldPc), .ldScore(ldScore), .thrWrEn(thrWrEn), .thrWrData(thrWrData),
    .tierMode(tierMode), .lkPc(lkPc), .lkHit(lkHit), .lkLevel(lkLevel),
    .overflow(overflow)
  );

  function automatic int convLvl(input int s, input bit tier, input int thr);
    if (tier) return (s >= 99) ? 2 : ((s >= 1) ? 1 : 0);
    return (s >= thr) ? 2 : 0;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  // Compare at negedge, then advance the model at the posedge
  task automatic tick(input string req);
    bit expHit;
    int expLvl;
    @(negedge clk);
    expHit = mdl.exists(lkPc);
    expLvl = expHit ? int'(mdl[lkPc]) : 0;
    nChk++;
    if (lkHit !== expHit || lkLevel !== expLvl[1:0] || overflow !== mOvf) begin
      nFail++;
      $display("FAIL %s pc=%h hit/lvl/ovf actual %0b/%0d/%0b expected %0b/%0d/%0b",
               req, lkPc, lkHit, lkLevel, overflow, expHit, expLvl, mOvf);
    end
    @(posedge clk);
    if (rstN) begin
      if (clrTable) begin
        mdl.delete();
        mOvf = 0;
      end else if (ldValid) begin
        int lv;
        lv = convLvl(int'(ldScore), tierMode, mThr);
        if (lv == 0) begin
          if (mdl.exists(ldPc)) mdl.delete(ldPc);
        end else if (mdl.exists(ldPc) || mdl.num() < ENT) begin
          mdl[ldPc] = lv;
        end else begin
          mOvf = 1;
        end
      end
      if (thrWrEn) mThr = int'(thrWrData);
    end
    #1;
  endtask

  task automatic load(input logic [31:0] pc, input int s, input string req);
    ldValid = 1; ldPc = pc; ldScore = 7'(s); lkPc = pc;
    tick(req);
    ldValid = 0;
    tick(req);
  endtask

  task automatic setThr(input int t, input string req);
    thrWrEn = 1; thrWrData = 7'(t);
    tick(req);
    thrWrEn = 0;
  endtask

  task automatic look(input logic [31:0] pc, input string req);
    lkPc = pc;
    tick(req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rstN = 0; clrTable = 0; ldValid = 0; ldPc = 0; ldScore = 0;
    thrWrEn = 0; thrWrData = 0; tierMode = 0; lkPc = 32'h100;
    mOvf = 0; mThr = THR0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1: reset state and threshold default
    look(32'h100, "R1");
    look(32'h104, "R1");
    load(32'h100, 0, "R1");
    load(32'h104, 1, "R1");

    // R3: two-level conversion
    load(32'h108, 70, "R3");
    load(32'h10C, 0, "R3");

    // R4: runtime threshold, same-cycle write uses old value
    setThr(60, "R4");
    load(32'h110, 59, "R4");
    load(32'h114, 60, "R4");
    load(32'h118, 61, "R4");
    thrWrEn = 1; thrWrData = 7'd90;
    load(32'h11C, 70, "R4");
    thrWrEn = 0;
    load(32'h120, 70, "R4");

    // R5: three-tier boundaries
    tierMode = 1;
    load(32'h200, 0, "R5");
    load(32'h204, 1, "R5");
    load(32'h208, 98, "R5");

    // R6: overwrite in place
    load(32'h204, 100, "R6");

    // R7: default level removes the entry
    tierMode = 0;
    load(32'h108, 10, "R7");
    load(32'h500, 10, "R7");

    // fill the table
    tierMode = 1;
    load(32'h20C, 99, "R5");
    load(32'h210, 100, "R5");

    // R8: full table refuses a new address
    load(32'h300, 100, "R8");
    look(32'h300, "R8");
    foreach (mdl[k]) look(k, "R2");
    load(32'h104, 50, "R8");

    // R10: freed slot is reused
    load(32'h114, 0, "R10");
    load(32'h300, 50, "R10");
    look(32'h104, "R10");

    // R9: clear beats a simultaneous load
    clrTable = 1; ldValid = 1; ldPc = 32'h400; ldScore = 7'd100; lkPc = 32'h104;
    tick("R9");
    clrTable = 0; ldValid = 0;
    look(32'h400, "R9");
    look(32'h104, "R9");

    // R2: mixed random traffic, compared every cycle
    for (int i = 0; i < 400; i++) begin
      ldValid   = ($urandom_range(0, 2) != 0);
      ldPc      = 32'h1000 + 4 * $urandom_range(0, 11);
      ldScore   = 7'($urandom_range(0, 100));
      tierMode  = $urandom_range(0, 1);
      thrWrEn   = ($urandom_range(0, 15) == 0);
      thrWrData = 7'($urandom_range(0, 100));
      clrTable  = ($urandom_range(0, 63) == 0);
      lkPc      = 32'h1000 + 4 * $urandom_range(0, 11);
      tick("R2");
    end
    clrTable = 0; ldValid = 0; thrWrEn = 0;
    tick("R2");

    finish_run();
  end

endmodule